// File: doc/BRIEF.md
# Processor Supervisor Reset Controller

This block generates the reset for a processor from three independent causes: a supply-fail flag from an external comparator, a manual push-button, and a watchdog that the running software must service. All three feed one reset stretcher. Once every cause has cleared, the stretcher keeps reset asserted for a fixed hold time, so both the supply and the processor have time to settle before code starts to run.

All timing is counted in ticks. A tick is a one-cycle enable on the system clock, nominally once per millisecond. The raw push-button and watchdog strobe levels pass through two-flop synchronisers first. The push-button is then debounced, and the strobe is edge-detected. The watchdog period is chosen by a 2-bit select. The watchdog has no disable: it is armed whenever reset is released, and it ignores the strobe while reset is asserted. The active-high and active-low reset outputs are always complementary.

Top module: `supervisor_reset`

## Requirements
- R1: When `supply_low` is high at a clock edge, `cpu_reset` is high after that edge, and it stays high for as long as `supply_low` stays high.
- R2: Once every cause has cleared, `cpu_reset` stays high for exactly 250 more ticks and then goes low. A supply cause that clears at an edge gives release on the 250th tick edge after it. On power-on (`por_n` low), `cpu_reset` is high at once, and it releases 250 ticks after `por_n` rises.
- R3: `wd_sel` sets the watchdog period: 2'b00 gives 150 ticks, 2'b01 gives 610 ticks, and 2'b10 or 2'b11 gives 1200 ticks. If no valid strobe edge arrives within the period after release, reset reasserts between P and P+2 ticks after release. That watchdog reset then lasts the full 250-tick hold.
- R4: Only a high-to-low transition of the synchronised strobe restarts the watchdog count. A strobe held high or held low never services it, and the watchdog cannot be turned off.
- R5: When `button_raw` is low (pressed; high means released) for fewer than 20 consecutive ticks, no reset results. When it is low for 20 ticks or more, reset is raised within 25 cycles of the press. Reset is held while the button is low, and the 250-tick hold starts once it is released.
- R6: Strobe edges are ignored while reset is asserted. The watchdog count starts from zero on the cycle reset is released, so strobe activity during reset does not change the next timeout.
- R7: `cpu_reset_n` is always the logical inverse of `cpu_reset`.
- R8: The hold, debounce and watchdog counters advance only on cycles where `tick` is high. With `tick` low, an asserted reset is never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Time-base enable, one cycle per tick |
| supply_low | input | 1 | Synchronised supply-fail flag, active high |
| button_raw | input | 1 | Raw push-button level, low when pressed |
| wd_strobe_raw | input | 1 | Raw watchdog strobe from the processor |
| wd_sel | input | 2 | Watchdog period select (00 short, 01 middle, 1x long) |
| cpu_reset | output | 1 | Processor reset, active high |
| cpu_reset_n | output | 1 | Processor reset, active low |

## Verification
On every cycle, the assertions check the following: a supply, button or watchdog cause raises reset on the next edge; a release happens only on a tick with no cause present; a held reset survives cycles without a tick; the expiry pulse is a single cycle; a falling strobe edge outside reset prevents expiry; and expiry never fires across a reset. Only the bench scenarios can show the absolute durations. These are the exact 250-tick hold, the three watchdog periods measured from release, and the 20-tick debounce boundary, where a 19-tick press is filtered and a longer one is recognised. The same holds for the end-to-end claim that constant strobe levels never service the watchdog.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Watchdog period in ticks for a given select code: 00 short, 01 middle, 1x long.
  function automatic int unsigned wd_limit(input logic [1:0] sel,
                                           input int unsigned p_short,
                                           input int unsigned p_mid,
                                           input int unsigned p_long);
    int unsigned lim;
    case (sel)
      2'b00:   lim = p_short;
      2'b01:   lim = p_mid;
      default: lim = p_long;
    endcase
    return lim;
  endfunction

  // Counter width able to hold values 0..n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
  parameter int unsigned WIDTH = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        meta_q <= RESET_VAL[b];
        sync_q <= RESET_VAL[b];
      end else begin
        meta_q <= d[b];
        sync_q <= meta_q;
      end
    end
    assign q[b] = sync_q;
  end

endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
  parameter int unsigned DB_TICKS = 20
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic btn_level,   // synchronised, 1 = released
  output logic pressed
);
  import sup_pkg::*;

  localparam int unsigned DW = cnt_width(DB_TICKS);
  localparam logic [DW-1:0] DB_MAX = DW'(DB_TICKS);

  logic [DW-1:0] low_cnt;
  logic          low_full;

  assign low_full = (low_cnt == DB_MAX);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      low_cnt <= '0;
    end else if (btn_level) begin
      low_cnt <= '0;
    end else if (tick && !low_full) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  // Release ends the press at once; the stretcher supplies the hold.
  assign pressed = low_full && !btn_level;

  AST_PRESS_NEEDS_LOW: assert property (@(posedge clk) disable iff (!arst_n)
    pressed |-> $past(!btn_level)); // R5

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int unsigned P_SHORT = 150,
  parameter int unsigned P_MID   = 610,
  parameter int unsigned P_LONG  = 1200
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       tick,
  input  logic       hold,        // reset currently asserted
  input  logic       strobe_lvl,  // synchronised strobe
  input  logic [1:0] sel,
  output logic       expire
);
  import sup_pkg::*;

  localparam int unsigned CW = cnt_width(P_LONG);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;
  logic          strobe_prev;
  logic          strobe_fall;
  logic          at_limit;

  assign lim_m1      = CW'(wd_limit(sel, P_SHORT, P_MID, P_LONG) - 1);
  assign strobe_fall = strobe_prev && !strobe_lvl;
  // >= covers a select change that shortens the period mid-count.
  assign at_limit    = (cnt >= lim_m1);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt         <= '0;
      expire      <= 1'b0;
      strobe_prev <= 1'b1;
    end else begin
      strobe_prev <= strobe_lvl;
      expire      <= 1'b0;
      if (hold) begin
        cnt <= '0;
      end else if (strobe_fall) begin
        cnt <= '0;
      end else if (tick) begin
        if (at_limit) begin
          cnt    <= '0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_EXPIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!arst_n)
    expire |=> !expire); // R3
  AST_FALL_SERVICES: assert property (@(posedge clk) disable iff (!arst_n)
    (strobe_fall && !hold) |=> !expire); // R4
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!arst_n)
    (hold && $past(hold)) |-> !expire); // R6

endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int unsigned HOLD_TICKS = 250
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic cause,
  output logic rst_out
);
  import sup_pkg::*;

  localparam int unsigned HW = cnt_width(HOLD_TICKS);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

  logic [HW-1:0] hold_cnt;
  logic          rst_q;
  logic          hold_done;

  assign hold_done = rst_q && tick && !cause && (hold_cnt == HOLD_LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (cause) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (hold_done) begin
      rst_q    <= 1'b0;
      hold_cnt <= '0;
    end else if (rst_q && tick) begin
      hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assign rst_out = rst_q;

  AST_CAUSE_SETS: assert property (@(posedge clk) disable iff (!arst_n)
    cause |=> rst_q); // R1
  AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_q) |-> ($past(!cause) && $past(tick))); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!arst_n)
    (rst_q && !tick && !cause) |=> rst_q); // R8

endmodule

// File: rtl/supervisor_reset.sv
module supervisor_reset #(
  parameter int unsigned HOLD_TICKS = 250,
  parameter int unsigned DB_TICKS   = 20,
  parameter int unsigned P_SHORT    = 150,
  parameter int unsigned P_MID      = 610,
  parameter int unsigned P_LONG     = 1200
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick,
  input  logic       supply_low,
  input  logic       button_raw,
  input  logic       wd_strobe_raw,
  input  logic [1:0] wd_sel,
  output logic       cpu_reset,
  output logic       cpu_reset_n
);

  logic [1:0] sync_out;
  logic       btn_sync;
  logic       strobe_sync;
  logic       btn_pressed;
  logic       wd_expire;
  logic       any_cause;
  logic       rst_int;

  sup_sync2 #(.WIDTH(2), .RESET_VAL(2'b11)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .d      ({button_raw, wd_strobe_raw}),
    .q      (sync_out)
  );
  assign btn_sync    = sync_out[1];
  assign strobe_sync = sync_out[0];

  sup_debounce #(.DB_TICKS(DB_TICKS)) u_debounce (
    .clk       (clk),
    .arst_n    (por_n),
    .tick      (tick),
    .btn_level (btn_sync),
    .pressed   (btn_pressed)
  );

  sup_watchdog #(.P_SHORT(P_SHORT), .P_MID(P_MID), .P_LONG(P_LONG)) u_watchdog (
    .clk        (clk),
    .arst_n     (por_n),
    .tick       (tick),
    .hold       (rst_int),
    .strobe_lvl (strobe_sync),
    .sel        (wd_sel),
    .expire     (wd_expire)
  );

  assign any_cause = supply_low | btn_pressed | wd_expire;

  sup_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_stretch (
    .clk     (clk),
    .arst_n  (por_n),
    .tick    (tick),
    .cause   (any_cause),
    .rst_out (rst_int)
  );

  assign cpu_reset   = rst_int;
  assign cpu_reset_n = ~rst_int;

  AST_WD_TO_RESET: assert property (@(posedge clk) disable iff (!por_n)
    wd_expire |=> cpu_reset); // R3
  AST_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    supply_low |=> cpu_reset); // R1
  AST_PRESS_TO_RESET: assert property (@(posedge clk) disable iff (!por_n)
    btn_pressed |=> cpu_reset); // R5

endmodule

// File: tb/supervisor_reset_bench.sv
module supervisor_reset_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 250;
  localparam int DB   = 20;
  localparam int PS   = 150;
  localparam int PM   = 610;
  localparam int PL   = 1200;
  localparam int KICK_GAP = 40;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       tick = 1'b1;
  logic       supply_low = 1'b0;
  logic       button_raw = 1'b1;
  logic       wd_strobe_raw = 1'b1;
  logic [1:0] wd_sel = 2'b00;
  logic       cpu_reset;
  logic       cpu_reset_n;

  int  checks = 0;
  int  errors = 0;
  bit  kick_en = 1'b0;
  logic strobe_manual = 1'b1;
  int  kick_phase = 0;

  supervisor_reset u_supervisor_reset (
    .clk           (clk),
    .por_n         (por_n),
    .tick          (tick),
    .supply_low    (supply_low),
    .button_raw    (button_raw),
    .wd_strobe_raw (wd_strobe_raw),
    .wd_sel        (wd_sel),
    .cpu_reset     (cpu_reset),
    .cpu_reset_n   (cpu_reset_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Strobe driver: automatic toggling or a manual level.
  always @(negedge clk) begin
    if (kick_en) begin
      kick_phase++;
      if (kick_phase >= KICK_GAP) begin
        kick_phase = 0;
        wd_strobe_raw = ~wd_strobe_raw;
      end
    end else begin
      kick_phase = 0;
      wd_strobe_raw = strobe_manual;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_until(input logic level, input int limit, output int n);
    n = 0;
    while (cpu_reset !== level && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_pair(input string tag);
    check(cpu_reset_n === ~cpu_reset, tag, int'(cpu_reset_n), int'(~cpu_reset));
  endtask

  task automatic power_up(input logic strobe_lvl);
    int n;
    @(negedge clk);
    kick_en = 1'b0;
    strobe_manual = strobe_lvl;
    por_n = 1'b0;
    supply_low = 1'b0;
    button_raw = 1'b1;
    tick = 1'b1;
    cycles(3);
    check(cpu_reset === 1'b1, "R2 reset state during power-on", int'(cpu_reset), 1);
    check_pair("R7 outputs complementary in power-on");
    por_n = 1'b1;
    count_until(1'b0, 400, n);
    check(n >= HOLD && n <= HOLD + 2, "R2 power-up hold length", n, HOLD);
  endtask

  task automatic t_supply();
    int n;
    wd_sel = 2'b10;
    power_up(1'b1);
    kick_en = 1'b1;
    cycles(5);
    supply_low = 1'b1;
    @(negedge clk);
    check(cpu_reset === 1'b1, "R1 supply fail raises reset", int'(cpu_reset), 1);
    check_pair("R7 outputs complementary in supply reset");
    cycles(500);
    check(cpu_reset === 1'b1, "R1 reset held while supply low", int'(cpu_reset), 1);
    supply_low = 1'b0;
    count_until(1'b0, 400, n);
    check(n == HOLD, "R2 exact hold after supply clears", n, HOLD);
    check_pair("R7 outputs complementary after release");
  endtask

  task automatic t_tick();
    int n;
    wd_sel = 2'b10;
    power_up(1'b1);
    supply_low = 1'b1;
    cycles(3);
    tick = 1'b0;
    supply_low = 1'b0;
    cycles(400);
    check(cpu_reset === 1'b1, "R8 no release without ticks", int'(cpu_reset), 1);
    tick = 1'b1;
    count_until(1'b0, 400, n);
    check(n == HOLD, "R8 hold counts ticks only", n, HOLD);
  endtask

  task automatic t_period(input logic [1:0] sel, input int p, input logic lvl);
    int n;
    int m;
    wd_sel = sel;
    power_up(lvl);
    count_until(1'b1, p + 50, n);
    check(n >= p && n <= p + 2, $sformatf("R3 R4 timeout sel=%0d strobe=%0d", sel, lvl), n, p);
    count_until(1'b0, 400, m);
    check(m >= HOLD - 1 && m <= HOLD + 1, "R3 watchdog reset lasts full hold", m, HOLD);
  endtask

  task automatic t_service();
    int n;
    int highs;
    wd_sel = 2'b00;
    power_up(1'b1);
    kick_en = 1'b1;
    highs = 0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (cpu_reset !== 1'b0) highs++;
    end
    check(highs == 0, "R4 falling edges keep watchdog serviced", highs, 0);
    strobe_manual = wd_strobe_raw;
    kick_en = 1'b0;
    count_until(1'b1, 400, n);
    check(n >= 1 && n <= PS + 2, "R4 constant strobe does not service", n, PS);
  endtask

  task automatic t_strobe_in_reset();
    int n;
    wd_sel = 2'b00;
    power_up(1'b1);
    supply_low = 1'b1;
    for (int i = 0; i < 10; i++) begin
      strobe_manual = 1'b0;
      cycles(5);
      strobe_manual = 1'b1;
      cycles(5);
    end
    supply_low = 1'b0;
    count_until(1'b0, 400, n);
    check(n == HOLD, "R6 strobe in reset leaves hold unchanged", n, HOLD);
    count_until(1'b1, 400, n);
    check(n >= PS && n <= PS + 2, "R6 count starts from zero at release", n, PS);
  endtask

  task automatic t_button();
    int n;
    int highs;
    wd_sel = 2'b10;
    power_up(1'b1);
    kick_en = 1'b1;
    button_raw = 1'b0;
    cycles(DB - 1);
    button_raw = 1'b1;
    highs = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (cpu_reset !== 1'b0) highs++;
    end
    check(highs == 0, "R5 short press filtered", highs, 0);
    button_raw = 1'b0;
    count_until(1'b1, 100, n);
    check(n >= DB && n <= DB + 5, "R5 long press recognised", n, DB);
    cycles(100);
    check(cpu_reset === 1'b1, "R5 reset held while pressed", int'(cpu_reset), 1);
    button_raw = 1'b1;
    count_until(1'b0, 400, n);
    check(n >= HOLD && n <= HOLD + 4, "R2 hold after button release", n, HOLD);
    check_pair("R7 outputs complementary after button");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    finish_run();
  end

  initial begin
    t_supply();
    t_tick();
    t_period(2'b00, PS, 1'b1);
    t_period(2'b01, PM, 1'b0);
    t_period(2'b10, PL, 1'b1);
    t_period(2'b11, PL, 1'b0);
    t_service();
    t_strobe_in_reset();
    t_button();
    finish_run();
  end

endmodule